// File: doc/BRIEF.md
# Four-Port Pin Controller with Set/Clear Access

This block is a register-mapped controller for general-purpose pins, organised as four ports behind a 32-bit word bus. Software never writes a pin's output level or direction directly. Each of those two properties has its own pair of registers: one that raises bits and one that lowers them. A write therefore touches only the pins whose bits are 1 and needs no read-modify-write. The current output, direction and input levels can be read back from state registers.

Ports 0, 1 and 2 are regular: pin n is bit n everywhere. Port 3 is mixed. It has six bidirectional pins, twenty-four output-only pins and twenty-two input-only pins, and these sit at irregular bit positions. The direction of its bidirectional pins is kept in the upper bits of the port 2 direction registers. Port 2 also carries a 13-bit multiplexer selection register with the same set/clear access. Every pad input passes through a two-stage synchronizer before software can see it.

Top module: `pin_bank_ctrl`

## Requirements
- R1: For ports 0, 1 and 2, writing an output-set register drives high, on the next clock, every pin whose data bit n is 1. Pins whose bit is 0 keep their level, and outputs never change without a write.
- R2: Writing an output-clear register drives low, on the next clock, every pin whose data bit n is 1. Other pins are unchanged.
- R3: Writing a direction-set register turns the marked pins into outputs (output enable 1). Writing a direction-clear register turns them into inputs. The direction state register reads bit n as 1 for an output.
- R4: Word offsets. Port 0 uses 0x40 input, 0x44 output set, 0x48 output clear, 0x4C output state, 0x50 direction set, 0x54 direction clear and 0x58 direction state. Port 1 uses the same seven registers at 0x60 to 0x78. Port 2 uses 0x10, 0x14 and 0x18 for direction set, clear and state, 0x1C for input, and 0x20 and 0x24 for output set and clear. Port 3 uses 0x00 for input, 0x04 and 0x08 for output set and clear, and 0x0C for output state.
- R5: Port 3 bidirectional pin n (n = 0..5) takes its output level from bit n+25 of the port 3 output set/clear registers. Its direction comes from bit n+25 of the port 2 direction set/clear registers, and it reads back at bit n+25 of the port 2 direction state register.
- R6: The port 3 input register (0x00) shows bidirectional pins 0..4 at bits 10..14 and bidirectional pin 5 at bit 24. Input-only pins 0..9 appear at bits 0..9, pins 10..18 at bits 15..23 and pins 19..21 at bits 25..27. Bits 28..31 read 0.
- R7: Port 3 output-only pin n (n = 0..23) is set and cleared through bit n of 0x04 and 0x08. It reads back at bit n of 0x0C, and the other bits of 0x0C read 0.
- R8: The port 2 multiplexer selection register is raised by 0x28, lowered by 0x2C and read at 0x30, with 13 bits.
- R9: Read data appears on the bus one clock after the read strobe and is 0 in any cycle that follows no read. Set and clear registers and unmapped offsets read 0.
- R10: Writes to input, output-state or direction-state registers change nothing.
- R11: Reset drives all outputs low, makes all bidirectional pins inputs, clears the multiplexer selection and the read data.
- R12: A pad level change is seen by a read whose strobe is sampled at the third rising edge after the change. Reads sampled at the first two edges return the previous level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Single-cycle write strobe |
| busRdEn | input | 1 | Single-cycle read strobe |
| busAddr | input | 8 | Byte offset of the register |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Registered read data |
| p0PadIn | input | 8 | Port 0 pad levels |
| p1PadIn | input | 24 | Port 1 pad levels |
| p2PadIn | input | 13 | Port 2 pad levels |
| p3BiPadIn | input | 6 | Port 3 bidirectional pad levels |
| p3InPadIn | input | 22 | Port 3 input-only pad levels |
| p0PadOut | output | 8 | Port 0 output levels |
| p0PadOe | output | 8 | Port 0 output enables |
| p1PadOut | output | 24 | Port 1 output levels |
| p1PadOe | output | 24 | Port 1 output enables |
| p2PadOut | output | 13 | Port 2 output levels |
| p2PadOe | output | 13 | Port 2 output enables |
| p2MuxSel | output | 13 | Port 2 multiplexer selection |
| p3BiPadOut | output | 6 | Port 3 bidirectional output levels |
| p3BiPadOe | output | 6 | Port 3 bidirectional output enables |
| p3OutPad | output | 24 | Port 3 output-only levels |

## Verification
The properties assume that a bus write or read strobe lasts exactly one clock, and that address and data are steady while it is high. They also assume the two strobes never name the same cycle with a stale address. The stimulus raises each strobe for one cycle at a falling edge and drops it at the next falling edge, and it never overlaps a read with a write. Pad inputs change only on falling edges. The sync-latency expectations therefore count whole rising edges from the change.

// File: rtl/pin_bank_pkg.sv
package pin_bank_pkg;

  localparam int ADDR_W      = 8;
  localparam int DATA_W      = 32;
  localparam int P0_W        = 8;
  localparam int P1_W        = 24;
  localparam int P2_W        = 13;
  localparam int P3_BI_W     = 6;
  localparam int P3_GPO_W    = 24;
  localparam int P3_GPI_W    = 22;
  localparam int SYNC_STAGES = 2;
  localparam int SYNC_W      = P0_W + P1_W + P2_W + P3_BI_W + P3_GPI_W;

  // bidirectional port 3 pins: write/direction lane base, and readback lanes
  localparam int P3_BI_LSB   = 25;
  localparam int P3_BI_RD_LO = 10;
  localparam int P3_BI_RD_TOP = 24;
  localparam int P3_IN_SPAN  = 28;

  // register offsets
  localparam logic [ADDR_W-1:0] OFF_P3_IN   = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_P3_OSET = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_P3_OCLR = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_P3_OST  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_P2_DSET = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_P2_DCLR = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_P2_DST  = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_P2_IN   = 8'h1C;
  localparam logic [ADDR_W-1:0] OFF_P2_OSET = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_P2_OCLR = 8'h24;
  localparam logic [ADDR_W-1:0] OFF_P2_MSET = 8'h28;
  localparam logic [ADDR_W-1:0] OFF_P2_MCLR = 8'h2C;
  localparam logic [ADDR_W-1:0] OFF_P2_MST  = 8'h30;
  localparam logic [ADDR_W-1:0] OFF_P0_IN   = 8'h40;
  localparam logic [ADDR_W-1:0] OFF_P0_OSET = 8'h44;
  localparam logic [ADDR_W-1:0] OFF_P0_OCLR = 8'h48;
  localparam logic [ADDR_W-1:0] OFF_P0_OST  = 8'h4C;
  localparam logic [ADDR_W-1:0] OFF_P0_DSET = 8'h50;
  localparam logic [ADDR_W-1:0] OFF_P0_DCLR = 8'h54;
  localparam logic [ADDR_W-1:0] OFF_P0_DST  = 8'h58;
  localparam logic [ADDR_W-1:0] OFF_P1_IN   = 8'h60;
  localparam logic [ADDR_W-1:0] OFF_P1_OSET = 8'h64;
  localparam logic [ADDR_W-1:0] OFF_P1_OCLR = 8'h68;
  localparam logic [ADDR_W-1:0] OFF_P1_OST  = 8'h6C;
  localparam logic [ADDR_W-1:0] OFF_P1_DSET = 8'h70;
  localparam logic [ADDR_W-1:0] OFF_P1_DCLR = 8'h74;
  localparam logic [ADDR_W-1:0] OFF_P1_DST  = 8'h78;

  // strobes from the decoder to the datapath, one per set/clear register
  typedef struct packed {
    logic p0OutSet;
    logic p0OutClr;
    logic p0DirSet;
    logic p0DirClr;
    logic p1OutSet;
    logic p1OutClr;
    logic p1DirSet;
    logic p1DirClr;
    logic p2OutSet;
    logic p2OutClr;
    logic p2DirSet;
    logic p2DirClr;
    logic p2MuxSet;
    logic p2MuxClr;
    logic p3OutSet;
    logic p3OutClr;
  } wrStrobe_t;

  typedef enum logic [3:0] {
    RD_NONE,
    RD_P0_IN,
    RD_P0_OUT,
    RD_P0_DIR,
    RD_P1_IN,
    RD_P1_OUT,
    RD_P1_DIR,
    RD_P2_IN,
    RD_P2_DIR,
    RD_P2_MUX,
    RD_P3_IN,
    RD_P3_OUT
  } rdSel_t;

  // write-one-to-set / write-one-to-clear update of a word
  function automatic logic [DATA_W-1:0] applyWord(
    input logic [DATA_W-1:0] cur,
    input logic [DATA_W-1:0] data,
    input logic              doSet,
    input logic              doClr
  );
    logic [DATA_W-1:0] res;
    res = cur;
    if (doSet) res = res | data;
    if (doClr) res = res & ~data;
    return res;
  endfunction

  // true for lanes of the port 3 input word taken by bidirectional readback
  function automatic logic isBiLane(input int lane);
    return ((lane >= P3_BI_RD_LO) && (lane < P3_BI_RD_LO + P3_BI_W - 1)) ||
           (lane == P3_BI_RD_TOP);
  endfunction

  // assemble the irregular port 3 input word
  function automatic logic [DATA_W-1:0] p3InWord(
    input logic [P3_BI_W-1:0]  bi,
    input logic [P3_GPI_W-1:0] gpi
  );
    logic [DATA_W-1:0] w;
    int k;
    w = '0;
    k = 0;
    for (int lane = 0; lane < P3_IN_SPAN; lane++) begin
      if (isBiLane(lane)) begin
        if (lane == P3_BI_RD_TOP) w[lane] = bi[P3_BI_W-1];
        else                      w[lane] = bi[lane - P3_BI_RD_LO];
      end else if (k < P3_GPI_W) begin
        w[lane] = gpi[k];
        k++;
      end
    end
    return w;
  endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] q;
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q <= '0;
        else       q <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q <= '0;
        else       q <= g_stage[s-1].q;
      end
    end
  end

  assign dout = g_stage[STAGES-1].q;

endmodule

// File: rtl/pin_bank_decode.sv
module pin_bank_decode
  import pin_bank_pkg::*;
(
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  output wrStrobe_t         wrStb,
  output rdSel_t            rdSel,
  output logic              rdReq
);

  always_comb begin
    wrStb = '0;
    rdSel = RD_NONE;
    unique case (busAddr)
      OFF_P0_IN:   rdSel = RD_P0_IN;
      OFF_P0_OSET: wrStb.p0OutSet = busWrEn;
      OFF_P0_OCLR: wrStb.p0OutClr = busWrEn;
      OFF_P0_OST:  rdSel = RD_P0_OUT;
      OFF_P0_DSET: wrStb.p0DirSet = busWrEn;
      OFF_P0_DCLR: wrStb.p0DirClr = busWrEn;
      OFF_P0_DST:  rdSel = RD_P0_DIR;
      OFF_P1_IN:   rdSel = RD_P1_IN;
      OFF_P1_OSET: wrStb.p1OutSet = busWrEn;
      OFF_P1_OCLR: wrStb.p1OutClr = busWrEn;
      OFF_P1_OST:  rdSel = RD_P1_OUT;
      OFF_P1_DSET: wrStb.p1DirSet = busWrEn;
      OFF_P1_DCLR: wrStb.p1DirClr = busWrEn;
      OFF_P1_DST:  rdSel = RD_P1_DIR;
      OFF_P2_IN:   rdSel = RD_P2_IN;
      OFF_P2_OSET: wrStb.p2OutSet = busWrEn;
      OFF_P2_OCLR: wrStb.p2OutClr = busWrEn;
      OFF_P2_DSET: wrStb.p2DirSet = busWrEn;
      OFF_P2_DCLR: wrStb.p2DirClr = busWrEn;
      OFF_P2_DST:  rdSel = RD_P2_DIR;
      OFF_P2_MSET: wrStb.p2MuxSet = busWrEn;
      OFF_P2_MCLR: wrStb.p2MuxClr = busWrEn;
      OFF_P2_MST:  rdSel = RD_P2_MUX;
      OFF_P3_IN:   rdSel = RD_P3_IN;
      OFF_P3_OSET: wrStb.p3OutSet = busWrEn;
      OFF_P3_OCLR: wrStb.p3OutClr = busWrEn;
      OFF_P3_OST:  rdSel = RD_P3_OUT;
      default:     rdSel = RD_NONE;
    endcase
  end

  assign rdReq = busRdEn;

endmodule

// File: rtl/pin_bank_path.sv
module pin_bank_path
  import pin_bank_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  wrStrobe_t           wrStb,
  input  rdSel_t              rdSel,
  input  logic                rdReq,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  input  logic [P0_W-1:0]     p0PadIn,
  input  logic [P1_W-1:0]     p1PadIn,
  input  logic [P2_W-1:0]     p2PadIn,
  input  logic [P3_BI_W-1:0]  p3BiPadIn,
  input  logic [P3_GPI_W-1:0] p3InPadIn,
  output logic [P0_W-1:0]     p0Out,
  output logic [P0_W-1:0]     p0Dir,
  output logic [P1_W-1:0]     p1Out,
  output logic [P1_W-1:0]     p1Dir,
  output logic [P2_W-1:0]     p2Out,
  output logic [P2_W-1:0]     p2Dir,
  output logic [P2_W-1:0]     p2Mux,
  output logic [P3_BI_W-1:0]  p3BiOut,
  output logic [P3_BI_W-1:0]  p3BiDir,
  output logic [P3_GPO_W-1:0] p3Gpo
);

  localparam int SH_P1  = P0_W;
  localparam int SH_P2  = SH_P1 + P1_W;
  localparam int SH_BI  = SH_P2 + P2_W;
  localparam int SH_GPI = SH_BI + P3_BI_W;

  // ---------------- input synchronizers ----------------
  logic [SYNC_W-1:0] rawIn;
  logic [SYNC_W-1:0] syncIn;

  assign rawIn = {p3InPadIn, p3BiPadIn, p2PadIn, p1PadIn, p0PadIn};

  pin_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) i_sync (
    .clk (clk),
    .rstN(rstN),
    .din (rawIn),
    .dout(syncIn)
  );

  logic [P0_W-1:0]     p0InS;
  logic [P1_W-1:0]     p1InS;
  logic [P2_W-1:0]     p2InS;
  logic [P3_BI_W-1:0]  p3BiInS;
  logic [P3_GPI_W-1:0] p3GpiInS;

  assign p0InS    = syncIn[SH_P1-1:0];
  assign p1InS    = syncIn[SH_P2-1:SH_P1];
  assign p2InS    = syncIn[SH_BI-1:SH_P2];
  assign p3BiInS  = syncIn[SH_GPI-1:SH_BI];
  assign p3GpiInS = syncIn[SYNC_W-1:SH_GPI];

  // ---------------- next-state computation ----------------
  logic [DATA_W-1:0] laneHigh;
  logic [DATA_W-1:0] nP0Out, nP0Dir, nP1Out, nP1Dir;
  logic [DATA_W-1:0] nP2Out, nP2Dir, nP2Mux;
  logic [DATA_W-1:0] nP3BiOut, nP3BiDir, nP3Gpo;

  assign laneHigh = wrData >> P3_BI_LSB;

  always_comb begin
    nP0Out   = applyWord(DATA_W'(p0Out), wrData, wrStb.p0OutSet, wrStb.p0OutClr);
    nP0Dir   = applyWord(DATA_W'(p0Dir), wrData, wrStb.p0DirSet, wrStb.p0DirClr);
    nP1Out   = applyWord(DATA_W'(p1Out), wrData, wrStb.p1OutSet, wrStb.p1OutClr);
    nP1Dir   = applyWord(DATA_W'(p1Dir), wrData, wrStb.p1DirSet, wrStb.p1DirClr);
    nP2Out   = applyWord(DATA_W'(p2Out), wrData, wrStb.p2OutSet, wrStb.p2OutClr);
    nP2Dir   = applyWord(DATA_W'(p2Dir), wrData, wrStb.p2DirSet, wrStb.p2DirClr);
    nP2Mux   = applyWord(DATA_W'(p2Mux), wrData, wrStb.p2MuxSet, wrStb.p2MuxClr);
    // port 3 bidirectional lanes share registers with other pins
    nP3BiOut = applyWord(DATA_W'(p3BiOut), laneHigh, wrStb.p3OutSet, wrStb.p3OutClr);
    nP3BiDir = applyWord(DATA_W'(p3BiDir), laneHigh, wrStb.p2DirSet, wrStb.p2DirClr);
    nP3Gpo   = applyWord(DATA_W'(p3Gpo), wrData, wrStb.p3OutSet, wrStb.p3OutClr);
  end

  // ---------------- state registers ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      p0Out   <= '0;
      p0Dir   <= '0;
      p1Out   <= '0;
      p1Dir   <= '0;
      p2Out   <= '0;
      p2Dir   <= '0;
      p2Mux   <= '0;
      p3BiOut <= '0;
      p3BiDir <= '0;
      p3Gpo   <= '0;
    end else begin
      p0Out   <= nP0Out[P0_W-1:0];
      p0Dir   <= nP0Dir[P0_W-1:0];
      p1Out   <= nP1Out[P1_W-1:0];
      p1Dir   <= nP1Dir[P1_W-1:0];
      p2Out   <= nP2Out[P2_W-1:0];
      p2Dir   <= nP2Dir[P2_W-1:0];
      p2Mux   <= nP2Mux[P2_W-1:0];
      p3BiOut <= nP3BiOut[P3_BI_W-1:0];
      p3BiDir <= nP3BiDir[P3_BI_W-1:0];
      p3Gpo   <= nP3Gpo[P3_GPO_W-1:0];
    end
  end

  // ---------------- read path ----------------
  logic [DATA_W-1:0] rdWord;

  always_comb begin
    unique case (rdSel)
      RD_P0_IN:  rdWord = DATA_W'(p0InS);
      RD_P0_OUT: rdWord = DATA_W'(p0Out);
      RD_P0_DIR: rdWord = DATA_W'(p0Dir);
      RD_P1_IN:  rdWord = DATA_W'(p1InS);
      RD_P1_OUT: rdWord = DATA_W'(p1Out);
      RD_P1_DIR: rdWord = DATA_W'(p1Dir);
      RD_P2_IN:  rdWord = DATA_W'(p2InS);
      RD_P2_DIR: rdWord = DATA_W'(p2Dir) | (DATA_W'(p3BiDir) << P3_BI_LSB);
      RD_P2_MUX: rdWord = DATA_W'(p2Mux);
      RD_P3_IN:  rdWord = p3InWord(p3BiInS, p3GpiInS);
      RD_P3_OUT: rdWord = DATA_W'(p3Gpo);
      default:   rdWord = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      rdData <= '0;
    else if (rdReq) rdData <= rdWord;
    else            rdData <= '0;
  end

endmodule

// File: rtl/pin_bank_ctrl.sv
module pin_bank_ctrl
  import pin_bank_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWrEn,
  input  logic                busRdEn,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWrData,
  output logic [DATA_W-1:0]   busRdData,
  input  logic [P0_W-1:0]     p0PadIn,
  input  logic [P1_W-1:0]     p1PadIn,
  input  logic [P2_W-1:0]     p2PadIn,
  input  logic [P3_BI_W-1:0]  p3BiPadIn,
  input  logic [P3_GPI_W-1:0] p3InPadIn,
  output logic [P0_W-1:0]     p0PadOut,
  output logic [P0_W-1:0]     p0PadOe,
  output logic [P1_W-1:0]     p1PadOut,
  output logic [P1_W-1:0]     p1PadOe,
  output logic [P2_W-1:0]     p2PadOut,
  output logic [P2_W-1:0]     p2PadOe,
  output logic [P2_W-1:0]     p2MuxSel,
  output logic [P3_BI_W-1:0]  p3BiPadOut,
  output logic [P3_BI_W-1:0]  p3BiPadOe,
  output logic [P3_GPO_W-1:0] p3OutPad
);

  wrStrobe_t wrStb;
  rdSel_t    rdSel;
  logic      rdReq;

  pin_bank_decode i_decode (
    .busWrEn(busWrEn),
    .busRdEn(busRdEn),
    .busAddr(busAddr),
    .wrStb  (wrStb),
    .rdSel  (rdSel),
    .rdReq  (rdReq)
  );

  pin_bank_path i_path (
    .clk      (clk),
    .rstN     (rstN),
    .wrStb    (wrStb),
    .rdSel    (rdSel),
    .rdReq    (rdReq),
    .wrData   (busWrData),
    .rdData   (busRdData),
    .p0PadIn  (p0PadIn),
    .p1PadIn  (p1PadIn),
    .p2PadIn  (p2PadIn),
    .p3BiPadIn(p3BiPadIn),
    .p3InPadIn(p3InPadIn),
    .p0Out    (p0PadOut),
    .p0Dir    (p0PadOe),
    .p1Out    (p1PadOut),
    .p1Dir    (p1PadOe),
    .p2Out    (p2PadOut),
    .p2Dir    (p2PadOe),
    .p2Mux    (p2MuxSel),
    .p3BiOut  (p3BiPadOut),
    .p3BiDir  (p3BiPadOe),
    .p3Gpo    (p3OutPad)
  );

endmodule

// File: rtl/pin_bank_checker.sv
module pin_bank_checker
  import pin_bank_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                busWrEn,
  input logic                busRdEn,
  input logic [ADDR_W-1:0]   busAddr,
  input logic [DATA_W-1:0]   busWrData,
  input logic [DATA_W-1:0]   busRdData,
  input logic [P0_W-1:0]     p0PadOut,
  input logic [P0_W-1:0]     p0PadOe,
  input logic [P1_W-1:0]     p1PadOut,
  input logic [P2_W-1:0]     p2MuxSel,
  input logic [P3_BI_W-1:0]  p3BiPadOe,
  input logic [P3_GPO_W-1:0] p3OutPad
);

  assert_p0_set_R1: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == OFF_P0_OSET) |=>
      ((p0PadOut & $past(busWrData[P0_W-1:0])) == $past(busWrData[P0_W-1:0])));

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busWrEn |=> ($stable(p0PadOut) && $stable(p1PadOut) && $stable(p0PadOe) &&
                  $stable(p3BiPadOe) && $stable(p3OutPad) && $stable(p2MuxSel)));

  assert_p1_clr_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == OFF_P1_OCLR) |=>
      ((p1PadOut & $past(busWrData[P1_W-1:0])) == '0));

  assert_p0_dir_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == OFF_P0_DSET) |=>
      ((p0PadOe & $past(busWrData[P0_W-1:0])) == $past(busWrData[P0_W-1:0])));

  assert_p3_dir_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == OFF_P2_DSET) |=>
      ((p3BiPadOe & $past(busWrData[P3_BI_LSB+P3_BI_W-1:P3_BI_LSB])) ==
        $past(busWrData[P3_BI_LSB+P3_BI_W-1:P3_BI_LSB])));

  assert_gpo_clr_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == OFF_P3_OCLR) |=>
      ((p3OutPad & $past(busWrData[P3_GPO_W-1:0])) == '0));

  assert_mux_set_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == OFF_P2_MSET) |=>
      ((p2MuxSel & $past(busWrData[P2_W-1:0])) == $past(busWrData[P2_W-1:0])));

  assert_idle_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |=> (busRdData == '0));

  assert_state_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && (busAddr == OFF_P0_OST || busAddr == OFF_P0_DST)) |=>
      ($stable(p0PadOut) && $stable(p0PadOe)));

endmodule

bind pin_bank_ctrl pin_bank_checker i_checker (.*);

// File: tb/test_pin_bank_ctrl.sv
module test_pin_bank_ctrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [7:0]  p0PadIn = '0;
  logic [23:0] p1PadIn = '0;
  logic [12:0] p2PadIn = '0;
  logic [5:0]  p3BiPadIn = '0;
  logic [21:0] p3InPadIn = '0;
  logic [7:0]  p0PadOut, p0PadOe;
  logic [23:0] p1PadOut, p1PadOe;
  logic [12:0] p2PadOut, p2PadOe, p2MuxSel;
  logic [5:0]  p3BiPadOut, p3BiPadOe;
  logic [23:0] p3OutPad;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pin_bank_ctrl i_pin_bank_ctrl (.*);

  typedef struct packed {
    logic [7:0]  wAddr;
    logic [31:0] wData;
    logic [7:0]  rAddr;
    logic [31:0] rExp;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 19;
  localparam vec_t VECS [NVEC] = '{
    '{8'h44, 32'h000000A5, 8'h4C, 32'h000000A5, 8'd1},   // R1 port 0 set
    '{8'h44, 32'hFFFFFF5A, 8'h4C, 32'h000000FF, 8'd1},   // R1 width limit
    '{8'h48, 32'h0000000F, 8'h4C, 32'h000000F0, 8'd2},   // R2 port 0 clear
    '{8'h64, 32'h00ABCDEF, 8'h6C, 32'h00ABCDEF, 8'd1},   // R1 port 1 set
    '{8'h68, 32'h00000F0F, 8'h6C, 32'h00ABC0E0, 8'd2},   // R2 port 1 clear
    '{8'h50, 32'h0000003C, 8'h58, 32'h0000003C, 8'd3},   // R3 dir set
    '{8'h54, 32'h0000000C, 8'h58, 32'h00000030, 8'd3},   // R3 dir clear
    '{8'h70, 32'hFFFFFFFF, 8'h78, 32'h00FFFFFF, 8'd3},   // R3 port 1 dir
    '{8'h10, 32'hFFFFFFFF, 8'h18, 32'h7E001FFF, 8'd5},   // R5 shared dir
    '{8'h14, 32'h02000001, 8'h18, 32'h7C001FFE, 8'd5},   // R5 shared clear
    '{8'h04, 32'h42FFFFFF, 8'h0C, 32'h00FFFFFF, 8'd7},   // R7 gpo set
    '{8'h08, 32'h00F0000F, 8'h0C, 32'h000FFFF0, 8'd7},   // R7 gpo clear
    '{8'h28, 32'hFFFFFFFF, 8'h30, 32'h00001FFF, 8'd8},   // R8 mux set
    '{8'h2C, 32'h00000AAA, 8'h30, 32'h00001555, 8'd8},   // R8 mux clear
    '{8'h4C, 32'hFFFFFFFF, 8'h4C, 32'h000000F0, 8'd10},  // R10 out state write
    '{8'h58, 32'h00000000, 8'h58, 32'h00000030, 8'd10},  // R10 dir state write
    '{8'h00, 32'hFFFFFFFF, 8'h44, 32'h00000000, 8'd9},   // R9 set reads zero
    '{8'h00, 32'hFFFFFFFF, 8'h7C, 32'h00000000, 8'd9},   // R9 unmapped
    '{8'h00, 32'hFFFFFFFF, 8'h48, 32'h00000000, 8'd9}    // R9 clear reads zero
  };

  task automatic check(input int req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] addr, input logic [31:0] data);
    busWrEn   = 1'b1;
    busAddr   = addr;
    busWrData = data;
    @(negedge clk);
    busWrEn   = 1'b0;
    busWrData = '0;
  endtask

  task automatic busRead(input logic [7:0] addr, output logic [31:0] data);
    busRdEn = 1'b1;
    busAddr = addr;
    @(negedge clk);
    data    = busRdData;
    busRdEn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(11, "reset p0 out", 32'(p0PadOut), 32'h0);
    check(11, "reset p1 oe", 32'(p1PadOe), 32'h0);
    check(11, "reset p3 oe", 32'(p3BiPadOe), 32'h0);
    check(11, "reset rdata", busRdData, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    // table walk: write then read back (R1 R2 R3 R5 R7 R8 R9 R10)
    for (int i = 0; i < NVEC; i++) begin
      busWrite(VECS[i].wAddr, VECS[i].wData);
      busRead(VECS[i].rAddr, rd);
      check(int'(VECS[i].req), $sformatf("vector %0d", i), rd, VECS[i].rExp);
    end

    // pad-level results of the table (R4 R5 R7 R8)
    check(4, "p0 out pads", 32'(p0PadOut), 32'hF0);
    check(4, "p0 oe pads", 32'(p0PadOe), 32'h30);
    check(4, "p1 out pads", 32'(p1PadOut), 32'hABC0E0);
    check(4, "p1 oe pads", 32'(p1PadOe), 32'hFFFFFF);
    check(5, "p2 oe pads", 32'(p2PadOe), 32'h1FFE);
    check(5, "p3 bidir oe", 32'(p3BiPadOe), 32'h3E);
    check(5, "p3 bidir out", 32'(p3BiPadOut), 32'h21);
    check(7, "p3 gpo pads", 32'(p3OutPad), 32'h0FFFF0);
    check(8, "mux pads", 32'(p2MuxSel), 32'h1555);

    // port 2 output set and clear (R1 R2)
    busWrite(8'h20, 32'hFFFF1234);
    check(1, "p2 out set", 32'(p2PadOut), 32'h1234);
    busWrite(8'h24, 32'h00000034);
    check(2, "p2 out clear", 32'(p2PadOut), 32'h1200);

    // input registers (R4 R6)
    p0PadIn   = 8'h5A;
    p1PadIn   = 24'h123456;
    p2PadIn   = 13'h0ABC;
    p3BiPadIn = 6'b101011;
    p3InPadIn = 22'h3FFFFF;
    repeat (4) @(negedge clk);
    busRead(8'h40, rd); check(4, "p0 input", rd, 32'h5A);
    busRead(8'h60, rd); check(4, "p1 input", rd, 32'h123456);
    busRead(8'h1C, rd); check(4, "p2 input", rd, 32'h0ABC);
    busRead(8'h00, rd); check(6, "p3 input all", rd, 32'h0FFFAFFF);
    p3BiPadIn = 6'b000000;
    p3InPadIn = 22'h080401;
    repeat (4) @(negedge clk);
    busRead(8'h00, rd); check(6, "p3 input lanes", rd, 32'h02008001);

    // R9 read data returns to zero after an idle cycle
    @(negedge clk);
    check(9, "idle read data", busRdData, 32'h0);

    // R12 synchronizer latency
    p0PadIn = 8'hC3;
    busRead(8'h40, rd); check(12, "sync edge 1", rd, 32'h5A);
    busRead(8'h40, rd); check(12, "sync edge 2", rd, 32'h5A);
    busRead(8'h40, rd); check(12, "sync edge 3", rd, 32'hC3);

    // R11 reset in mid-run
    rstN = 1'b0;
    @(negedge clk);
    check(11, "mid reset p0 out", 32'(p0PadOut), 32'h0);
    check(11, "mid reset gpo", 32'(p3OutPad), 32'h0);
    check(11, "mid reset mux", 32'(p2MuxSel), 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    busRead(8'h18, rd); check(11, "dir after reset", rd, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule